// File: doc/BRIEF.md
# Dual-Bank Waveform Playback Memory

This block holds sample waveforms that a host loads in advance, and plays one of them back without a break toward a converter datapath. On every clock it delivers a pair of 14-bit samples, one even and one odd. Stored samples are 16 bits wide and sit in two banks, one for even and one for odd samples. Each bank has two RAMs of 64-bit words, and each word carries four samples. An index called the pair index addresses one even/odd pair across the whole pool.

Playback runs in one of two modes. In dual mode the pool splits into two equal halves, and these hold waveform A and waveform B. In pooled mode any number of waveforms share the pool, and one of them is picked by a start pair and a length. A chain of three multiplexers picks the output source. The choices are live port A, live port B, both ports interleaved, or the stored waveform. Every source reaches the output after the same fixed number of clock edges.

Top module: `wave_play_mem`

## Requirements
- R1: While `rst_n` is low, `dac_even` and `dac_odd` are zero.
- R2: A host write with `host_addr[HA-1]`=0 targets the even bank and with 1 the odd bank. `host_addr[HA-2:0]` is the pair index shifted right by two. Lane j (`host_wdata[16j+15:16j]`) holds the sample of pair index 4*word+j.
- R3: A host write while `play_en` is high changes no stored sample.
- R4: In dual mode (`pool_mode`=0), waveform A starts at pair 0 and waveform B (`wave_sel`=1) starts at pair POOL/2. The length in pairs is `len_cfg[PW-2:0]`+1, and the top bit of `len_cfg` is ignored.
- R5: In pooled mode (`pool_mode`=1), playback starts at `start_cfg` and lasts `len_cfg`+1 pairs. The pair index wraps modulo the pool size.
- R6: While `play_en` is high, the pair index advances by one each cycle. After the last pair it returns to the start pair on the next cycle, with no gap.
- R7: While playing, changes to `start_cfg`, `len_cfg`, `pool_mode` or `wave_sel` take effect only when the current loop wraps.
- R8: While `play_en` is low, the pair index is held at the start pair that the present settings give. That pair is output continuously.
- R9: The source priority is: `src_mem`=1 selects memory. Otherwise `il_en`=1 gives even=`port_a[13:0]` and odd=`port_b[13:0]`. Otherwise `port_sel`=0 passes `port_a` and 1 passes `port_b`, with bits [13:0] as the even sample and [27:14] as the odd sample.
- R10: A stored sample s reaches the output as s[15:2].
- R11: An input or pair index present before rising edge k appears at the output just after edge k+LAT-1, where LAT=DLY+2 (28 by default). This holds for every source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_en | input | 1 | Playback running; blocks host writes |
| pool_mode | input | 1 | 1 pooled mode, 0 dual mode |
| wave_sel | input | 1 | Dual mode: 0 waveform A, 1 waveform B |
| src_mem | input | 1 | Output taken from memory |
| il_en | input | 1 | Interleave the live ports |
| port_sel | input | 1 | Live port choice: 0 A, 1 B |
| start_cfg | input | PW | Pooled start pair index |
| len_cfg | input | PW | Length in pairs minus one |
| host_we | input | 1 | Host write enable |
| host_addr | input | HA | Host word address {bank, word} |
| host_wdata | input | 64 | Four 16-bit samples |
| port_a | input | 28 | Live pair A {odd, even} |
| port_b | input | 28 | Live pair B {odd, even} |
| dac_even | output | 14 | Even output sample |
| dac_odd | output | 14 | Odd output sample |

## Verification
The hardest situations to reach are a configuration change that arrives while a loop is part way through, and a loop that runs past the top of the pool back to pair zero. The bench plays short loops so that wraps come often. It rewrites start and length in the middle of a loop, and it picks a pooled start a few pairs below the pool's top. A cycle-exact model predicts every output pair for every edge. A mismatch in when a change takes effect therefore shows up as a wrong sample.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
  localparam int SW = 16;
  localparam int OW = 14;

  typedef struct packed {
    logic [OW-1:0] odd;
    logic [OW-1:0] even;
  } pair_t;

  function automatic logic [OW-1:0] trunc_s(input logic [SW-1:0] s);
    return s[SW-1:SW-OW];
  endfunction

  function automatic logic [SW-1:0] lane_pick(input logic [63:0] w, input logic [1:0] l);
    return w[int'(l)*SW +: SW];
  endfunction
endpackage

// File: rtl/wpm_bank.sv
module wpm_bank import wpm_pkg::*; #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW:0]   waddr,
  input  logic [63:0]   wdata,
  input  logic [PW-1:0] raddr,
  output logic [SW-1:0] rsample
);
  logic [63:0] rd_w [2];
  logic        sel_q;
  logic [1:0]  lane_q;

  for (genvar r = 0; r < 2; r++) begin : g_ram
    logic [63:0] mem [DEPTH];
    logic [63:0] q;
    always_ff @(posedge clk) begin
      if (we && (waddr[AW] == 1'(r))) mem[waddr[AW-1:0]] <= wdata;
      q <= mem[raddr[AW+1:2]];
    end
    assign rd_w[r] = q;
  end

  always_ff @(posedge clk) begin
    sel_q  <= raddr[PW-1];
    lane_q <= raddr[1:0];
  end

  assign rsample = lane_pick(rd_w[sel_q], lane_q);
endmodule

// File: rtl/wpm_seq.sv
module wpm_seq #(
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          play_en,
  input  logic          pool_mode,
  input  logic          wave_sel,
  input  logic [PW-1:0] start_cfg,
  input  logic [PW-1:0] len_cfg,
  output logic [PW-1:0] rd_ptr,
  output logic          wrap
);
  localparam logic [PW-1:0] HALF_BASE = {1'b1, {(PW-1){1'b0}}};

  function automatic logic [PW-1:0] f_start(input logic pm, input logic ws,
                                           input logic [PW-1:0] st);
    if (pm) return st;
    return ws ? HALF_BASE : '0;
  endfunction

  function automatic logic [PW-1:0] f_len(input logic pm, input logic [PW-1:0] ln);
    if (pm) return ln;
    return {1'b0, ln[PW-2:0]};
  endfunction

  logic [PW-1:0] eff_start, eff_len;
  logic [PW-1:0] ptr, cnt, act_len;

  assign eff_start = f_start(pool_mode, wave_sel, start_cfg);
  assign eff_len   = f_len(pool_mode, len_cfg);
  assign wrap      = play_en && (cnt == act_len);
  assign rd_ptr    = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      cnt     <= '0;
      act_len <= '0;
    end else if (!play_en || wrap) begin
      ptr     <= eff_start;
      cnt     <= '0;
      act_len <= eff_len;
    end else begin
      ptr <= ptr + 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (play_en && !wrap) |=> (ptr == $past(ptr) + 1'b1)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_len); // R6
  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (play_en && !wrap) |=> $stable(act_len)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |=> (ptr == $past(eff_start) && cnt == '0)); // R8
endmodule

// File: rtl/wpm_route.sv
module wpm_route import wpm_pkg::*; #(
  parameter int DLY = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pair_t         port_a,
  input  pair_t         port_b,
  input  logic          src_mem,
  input  logic          il_en,
  input  logic          port_sel,
  input  logic [SW-1:0] mem_even,
  input  logic [SW-1:0] mem_odd,
  output pair_t         dout
);
  pair_t a_q, b_q, mux_q;
  logic  sm_q, il_q, ps_q;
  pair_t m0_live, m1_live, m2_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      sm_q <= 1'b0;
      il_q <= 1'b0;
      ps_q <= 1'b0;
    end else begin
      a_q  <= port_a;
      b_q  <= port_b;
      sm_q <= src_mem;
      il_q <= il_en;
      ps_q <= port_sel;
    end
  end

  assign m0_live = ps_q ? b_q : a_q;
  assign m1_live = il_q ? pair_t'{odd: b_q.even, even: a_q.even} : m0_live;
  assign m2_out  = sm_q ? pair_t'{odd: trunc_s(mem_odd), even: trunc_s(mem_even)} : m1_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mux_q <= '0;
    else        mux_q <= m2_out;
  end

  if (DLY == 0) begin : g_nodly
    assign dout = mux_q;
  end else begin : g_dly
    pair_t stg [DLY];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DLY; i++) stg[i] <= '0;
      end else begin
        stg[0] <= mux_q;
        for (int i = 1; i < DLY; i++) stg[i] <= stg[i-1];
      end
    end
    assign dout = stg[DLY-1];
  end
endmodule

// File: rtl/wave_play_mem.sv
module wave_play_mem import wpm_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int DLY   = 26,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 3,
  localparam int HA   = AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          play_en,
  input  logic          pool_mode,
  input  logic          wave_sel,
  input  logic          src_mem,
  input  logic          il_en,
  input  logic          port_sel,
  input  logic [PW-1:0] start_cfg,
  input  logic [PW-1:0] len_cfg,
  input  logic          host_we,
  input  logic [HA-1:0] host_addr,
  input  logic [63:0]   host_wdata,
  input  logic [27:0]   port_a,
  input  logic [27:0]   port_b,
  output logic [13:0]   dac_even,
  output logic [13:0]   dac_odd
);
  logic          we_even, we_odd, wrap;
  logic [PW-1:0] rd_ptr;
  logic [SW-1:0] s_even, s_odd;
  pair_t         dout;

  assign we_even = host_we && !play_en && !host_addr[HA-1];
  assign we_odd  = host_we && !play_en &&  host_addr[HA-1];

  wpm_seq #(.PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .pool_mode(pool_mode),
    .wave_sel(wave_sel), .start_cfg(start_cfg), .len_cfg(len_cfg),
    .rd_ptr(rd_ptr), .wrap(wrap)
  );

  wpm_bank #(.DEPTH(DEPTH)) u_even (
    .clk(clk), .we(we_even), .waddr(host_addr[AW:0]), .wdata(host_wdata),
    .raddr(rd_ptr), .rsample(s_even)
  );

  wpm_bank #(.DEPTH(DEPTH)) u_odd (
    .clk(clk), .we(we_odd), .waddr(host_addr[AW:0]), .wdata(host_wdata),
    .raddr(rd_ptr), .rsample(s_odd)
  );

  wpm_route #(.DLY(DLY)) u_route (
    .clk(clk), .rst_n(rst_n), .port_a(pair_t'(port_a)), .port_b(pair_t'(port_b)),
    .src_mem(src_mem), .il_en(il_en), .port_sel(port_sel),
    .mem_even(s_even), .mem_odd(s_odd), .dout(dout)
  );

  assign dac_even = dout.even;
  assign dac_odd  = dout.odd;

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    play_en |-> !(we_even || we_odd)); // R3
  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_even && we_odd)); // R2
  AST_WRAP_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && pool_mode && $stable(start_cfg)) |=> (rd_ptr == $past(start_cfg))); // R5
endmodule

// File: tb/test_wave_play_mem.sv
`timescale 1ns/1ps
module test_wave_play_mem;
  localparam int DEPTH = 256, DLY = 26, AW = 8, PW = 11, HA = 10;
  localparam int POOL = 2048, HALF = 1024, WPB = POOL/4, LAT = DLY + 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, play_en = 1'b0, pool_mode = 1'b0, wave_sel = 1'b0;
  logic src_mem = 1'b0, il_en = 1'b0, port_sel = 1'b0, host_we = 1'b0;
  logic [PW-1:0] start_cfg = '0, len_cfg = '0;
  logic [HA-1:0] host_addr = '0;
  logic [63:0]   host_wdata = '0;
  logic [27:0]   port_a = '0, port_b = '0;
  logic [13:0]   dac_even, dac_odd;

  wave_play_mem #(.DEPTH(DEPTH), .DLY(DLY)) i_wave_play_mem (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .pool_mode(pool_mode),
    .wave_sel(wave_sel), .src_mem(src_mem), .il_en(il_en), .port_sel(port_sel),
    .start_cfg(start_cfg), .len_cfg(len_cfg), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .port_a(port_a),
    .port_b(port_b), .dac_even(dac_even), .dac_odd(dac_odd)
  );

  int    n_cmp = 0, n_bad = 0, ecnt = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  logic [15:0]   m_even [POOL];
  logic [15:0]   m_odd  [POOL];
  logic [PW-1:0] mptr, mcnt, mlen;
  logic [27:0]   exph [64];

  function automatic logic [15:0] pat(input int bank, input int idx);
    return 16'(idx * 29 + bank * 7001 + 3);
  endfunction

  // Requirement model: expected pair per edge, pair index sequence, host writes
  always @(posedge clk or negedge rst_n) begin : model
    logic [27:0]   e;
    logic [PW-1:0] es, el;
    if (!rst_n) begin
      mptr <= '0; mcnt <= '0; mlen <= '0; ecnt <= 0;
    end else begin
      if (host_we && !play_en)
        for (int j = 0; j < 4; j++) begin
          if (host_addr[HA-1]) m_odd[{host_addr[AW:0], 2'(j)}]  <= host_wdata[16*j +: 16];
          else                 m_even[{host_addr[AW:0], 2'(j)}] <= host_wdata[16*j +: 16];
        end
      if (src_mem)    e = {m_odd[mptr][15:2], m_even[mptr][15:2]};
      else if (il_en) e = {port_b[13:0], port_a[13:0]};
      else            e = port_sel ? port_b : port_a;
      exph[ecnt % 64] <= e;
      ecnt <= ecnt + 1;
      es = pool_mode ? start_cfg : (wave_sel ? PW'(HALF) : '0);
      el = pool_mode ? len_cfg : {1'b0, len_cfg[PW-2:0]};
      if (!play_en || mcnt == mlen) begin
        mptr <= es; mcnt <= '0; mlen <= el;
      end else begin
        mptr <= mptr + 1'b1; mcnt <= mcnt + 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done && ecnt >= LAT) begin
      n_cmp++;
      if ({dac_odd, dac_even} !== exph[(ecnt - LAT) % 64]) begin
        n_bad++;
        $display("FAIL %s: odd/even actual %h/%h expected %h/%h", cur_req,
                 dac_odd, dac_even, exph[(ecnt - LAT) % 64][27:14], exph[(ecnt - LAT) % 64][13:0]);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cur_req = "R1";
    rst_n = 1'b0;
    port_a = 28'h1234567; port_b = 28'h7654321;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      n_cmp++;
      if (dac_even !== 14'd0 || dac_odd !== 14'd0) begin
        n_bad++;
        $display("FAIL R1: odd/even actual %h/%h expected 0/0", dac_odd, dac_even);
      end
    end
    rst_n = 1'b1;
    cycles(LAT + 4);
  endtask

  task automatic t_load;
    cur_req = "R2";
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < WPB; w++) begin
        @(negedge clk);
        host_we = 1'b1;
        host_addr = {1'(b), 9'(w)};
        for (int j = 0; j < 4; j++) host_wdata[16*j +: 16] = pat(b, w*4 + j);
      end
    @(negedge clk);
    host_we = 1'b0;
    cycles(2);
  endtask

  task automatic t_dual;
    cur_req = "R2/R4/R10";
    pool_mode = 1'b0; wave_sel = 1'b0; len_cfg = 11'd9; src_mem = 1'b1;
    cycles(3);
    play_en = 1'b1;
    cycles(45);
    cur_req = "R4/R7";
    wave_sel = 1'b1; len_cfg = 11'h405;
    cycles(50);
  endtask

  task automatic t_pool;
    cur_req = "R5";
    pool_mode = 1'b1; start_cfg = 11'd100; len_cfg = 11'd5;
    cycles(40);
    start_cfg = 11'd2044; len_cfg = 11'd7;
    cycles(50);
  endtask

  task automatic t_change;
    cur_req = "R6/R7";
    start_cfg = 11'd500; len_cfg = 11'd12;
    cycles(30);
    cycles(5);
    start_cfg = 11'd800; len_cfg = 11'd2;
    cycles(3);
    start_cfg = 11'd900; len_cfg = 11'd4;
    cycles(50);
  endtask

  task automatic t_nowrite;
    cur_req = "R3";
    start_cfg = 11'd300; len_cfg = 11'd3;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      host_we = 1'b1;
      host_addr = {1'(i & 1), 9'd75};
      host_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    end
    @(negedge clk);
    host_we = 1'b0;
    cycles(40);
  endtask

  task automatic t_stop;
    cur_req = "R8";
    play_en = 1'b0;
    cycles(40);
    start_cfg = 11'd302;
    cycles(40);
    cur_req = "R3/R8";
    play_en = 1'b1;
    cycles(40);
  endtask

  task automatic t_live;
    cur_req = "R9";
    src_mem = 1'b0; il_en = 1'b0; port_sel = 1'b0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      port_a = 28'(i * 32'h0010_2F31);
      port_b = 28'(i * 32'h0077_0A15 + 32'h5);
      if (i == 40) port_sel = 1'b1;
      if (i == 80) il_en = 1'b1;
    end
    cycles(LAT + 2);
  endtask

  task automatic t_latency;
    int cnt;
    cur_req = "R11";
    il_en = 1'b0; port_sel = 1'b0; src_mem = 1'b0;
    port_a = {14'd11, 14'd22};
    cycles(LAT + 3);
    @(negedge clk);
    port_a = {14'd333, 14'd444};
    cnt = 0;
    while (cnt < 60 && dac_even !== 14'd444) begin
      @(negedge clk);
      cnt++;
    end
    n_cmp++;
    if (cnt != LAT) begin
      n_bad++;
      $display("FAIL R11: latency actual %0d expected %0d", cnt, LAT);
    end
    cur_req = "R9/R10/R11";
    src_mem = 1'b1;
    cycles(LAT + 10);
  endtask

  initial begin
    t_reset();
    t_load();
    t_dual();
    t_pool();
    t_change();
    t_nowrite();
    t_stop();
    t_live();
    t_latency();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule